// File: doc/BRIEF.md
# Bit-Serial SIMD Element Logic

This block is the per-lane logic of a bit-serial SIMD array. It holds two lane-wide registers, X and Y. A vector of input bits (one bit-slice) arrives on each strobe, and the registers are rewritten lane by lane with any one of the sixteen two-input Boolean functions. The function is supplied as a 4-bit truth table. A three-bit operation code selects the target: X alone, Y alone, both, or X under a per-lane mask taken from Y. The mask can be used while Y itself is rewritten in the same cycle. In that case the mask is the Y value from before the edge.

The block also has a built-in add sequencer. It adds two fields held lane by lane, one bit position at a time, starting from the least significant bit. For each bit, the caller first presents the A slice and then the B slice. The block then runs two internal steps on its own. It publishes the sum slice with a one-cycle valid pulse, clears X, and leaves the carry-out in Y for the next bit. Before the first bit, software sets the carry-in by writing Y, for example by clearing both registers. Memory and lane permutation lie outside the block.

Top module: `bitser_pe_array`

## Requirements
- R1: While reset is applied, and after it is released, X, Y, the sum output and its valid flag are all zero and busy is low.
- R2: Code 0 (X update): each lane sets x to tt[2*x+f], where tt is the 4-bit truth table and f is that lane's slice bit. Y is unchanged.
- R3: Code 1 (Y update): each lane sets y to tt[2*y+f]. X is unchanged.
- R4: Code 2 (joint update): the same truth table rewrites both registers, each from its own old value and f.
- R5: Code 3 (masked X): lanes with y=1 take x = tt[2*x+f]. Lanes with y=0 keep x. Y is unchanged.
- R6: Code 4 (masked X with Y update): X is masked as in R5 by the Y value from before the edge, and in the same edge y becomes tt[2*y+f].
- R7: A cycle with the strobe low, or with code 7, changes neither X nor Y.
- R8: Code 5 (add, A slice), accepted only when no add is pending: x becomes x XOR (y AND f) and y becomes y XOR f. The block then waits for code 6 (add, B slice), which applies the same update using the B slice.
- R9: After the B slice edge, busy is high for exactly two cycles. The sum is valid for one cycle only, the second of those two cycles. At that point the sum output equals the Y value left by the B slice, which is the lane's A XOR B XOR carry.
- R10: At the end of the two internal steps, X is zero in every lane and Y holds each lane's carry-out. Repeating the sequence from LSB to MSB therefore produces the lane-wise binary sum.
- R11: Strobes that arrive while busy are ignored. While an add is waiting for its B slice, every code other than 6 is ignored. Code 6 is ignored when no add is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operation strobe |
| in_mode | input | 3 | Operation code (0..7) |
| in_tt | input | 4 | Truth table, indexed by {register bit, slice bit} |
| in_slice | input | LANES | Input bit-slice, one bit per lane |
| x_out | output | LANES | X register |
| y_out | output | LANES | Y register |
| sum_out | output | LANES | Last published sum slice |
| sum_vld | output | 1 | One-cycle pulse when sum_out carries a new slice |
| busy | output | 1 | Add sequencer running its internal steps |

## Verification
The bench targets masked operation. A design that took the mask from the freshly written Y under code 4 would corrupt exactly those lanes whose Y flips, and a design that ignored the mask would disturb lanes where Y is zero. It drives random truth tables so that swapped truth-table indexing, or a function applied to the wrong operand, shows up in X or Y. The add sequence is run over a multi-bit field with random operands in every lane, and the slices read out are compared with true binary addition. Carry loss, a late or doubled sum pulse, and X left non-zero all break that total. Strobes are also sent while busy, while an add waits for its B slice, and with code 6 when no add is pending; a design that accepted any of them would alter X or Y.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MD_X     = 3'd0;
  localparam logic [MODE_W-1:0] MD_Y     = 3'd1;
  localparam logic [MODE_W-1:0] MD_XY    = 3'd2;
  localparam logic [MODE_W-1:0] MD_XMSK  = 3'd3;
  localparam logic [MODE_W-1:0] MD_XMSKY = 3'd4;
  localparam logic [MODE_W-1:0] MD_ADD_A = 3'd5;
  localparam logic [MODE_W-1:0] MD_ADD_B = 3'd6;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_X,
    OP_Y,
    OP_XY,
    OP_XM,
    OP_XMY,
    OP_ADD,
    OP_ST3,
    OP_ST4
  } bsp_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAITB,
    SQ_STEP3,
    SQ_STEP4
  } bsp_seq_e;

endpackage

// File: rtl/bsp_bool_vec.sv
module bsp_bool_vec #(
  parameter int W = 16
) (
  input  logic [3:0]   tt,
  input  logic [W-1:0] s,
  input  logic [W-1:0] f,
  output logic [W-1:0] r
);

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign r[i] = tt[{s[i], f[i]}];
  end

endmodule

// File: rtl/bsp_seq_ctrl.sv
module bsp_seq_ctrl
  import bsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [MODE_W-1:0] mode,
  output bsp_op_e           op,
  output logic              busy
);

  bsp_seq_e state_q, state_d;

  always_comb begin
    op      = OP_NOP;
    state_d = state_q;
    case (state_q)
      SQ_IDLE: begin
        if (vld) begin
          case (mode)
            MD_X:     op = OP_X;
            MD_Y:     op = OP_Y;
            MD_XY:    op = OP_XY;
            MD_XMSK:  op = OP_XM;
            MD_XMSKY: op = OP_XMY;
            MD_ADD_A: begin
              op      = OP_ADD;
              state_d = SQ_WAITB;
            end
            default:  op = OP_NOP;
          endcase
        end
      end
      SQ_WAITB: begin
        if (vld && mode == MD_ADD_B) begin
          op      = OP_ADD;
          state_d = SQ_STEP3;
        end
      end
      SQ_STEP3: begin
        op      = OP_ST3;
        state_d = SQ_STEP4;
      end
      SQ_STEP4: begin
        op      = OP_ST4;
        state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q == SQ_STEP3) || (state_q == SQ_STEP4);

  // R11: strobes cannot shorten or extend the internal steps
  a_r11_busy_runs_through: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STEP3) |=> (state_q == SQ_STEP4));

  // R11: a pending add leaves only via the B slice
  a_r11_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_WAITB && !(vld && mode == MD_ADD_B)) |=> (state_q == SQ_WAITB));

endmodule

// File: rtl/bsp_xy_datapath.sv
module bsp_xy_datapath
  import bsp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bsp_op_e      op,
  input  logic [3:0]   tt,
  input  logic [W-1:0] f,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [W-1:0] sum_q,
  output logic         sum_vld_q
);

  logic [W-1:0] fx, fy;
  logic [W-1:0] x_d, y_d, sum_d;
  logic         x_en, y_en, sum_en;

  bsp_bool_vec #(.W(W)) u_fx (.tt(tt), .s(x_q), .f(f), .r(fx));
  bsp_bool_vec #(.W(W)) u_fy (.tt(tt), .s(y_q), .f(f), .r(fy));

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    x_en   = 1'b0;
    y_en   = 1'b0;
    sum_d  = y_q;
    sum_en = 1'b0;
    case (op)
      OP_X: begin
        x_d  = fx;
        x_en = 1'b1;
      end
      OP_Y: begin
        y_d  = fy;
        y_en = 1'b1;
      end
      OP_XY: begin
        x_d  = fx;
        y_d  = fy;
        x_en = 1'b1;
        y_en = 1'b1;
      end
      OP_XM: begin
        x_d  = (fx & y_q) | (x_q & ~y_q);
        x_en = 1'b1;
      end
      OP_XMY: begin
        x_d  = (fx & y_q) | (x_q & ~y_q);
        y_d  = fy;
        x_en = 1'b1;
        y_en = 1'b1;
      end
      OP_ADD: begin
        x_d  = x_q ^ (y_q & f);
        y_d  = y_q ^ f;
        x_en = 1'b1;
        y_en = 1'b1;
      end
      OP_ST3: begin
        x_d    = x_q ^ (y_q & y_q);
        x_en   = 1'b1;
        sum_en = 1'b1;
      end
      OP_ST4: begin
        x_d  = x_q ^ x_q;
        y_d  = y_q ^ x_q;
        x_en = 1'b1;
        y_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q       <= '0;
      y_q       <= '0;
      sum_q     <= '0;
      sum_vld_q <= 1'b0;
    end else begin
      if (x_en)   x_q   <= x_d;
      if (y_en)   y_q   <= y_d;
      if (sum_en) sum_q <= sum_d;
      sum_vld_q <= sum_en;
    end
  end

  // R5: lanes with a zero mask keep X
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_XM) |-> (((x_q ^ $past(x_q)) & ~$past(y_q)) == '0));

  // R6: the mask is the pre-edge Y, even though Y moves
  a_r6_old_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_XMY) |-> (((x_q ^ $past(x_q)) & ~$past(y_q)) == '0));

  // R7: no operation leaves both registers alone
  a_r7_nop_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_NOP) |-> ($stable(x_q) && $stable(y_q)));

  // R2: an X update does not touch Y
  a_r2_y_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_X) |-> $stable(y_q));

  // R9: the sum pulse lasts one cycle
  a_r9_sum_single: assert property (@(posedge clk) disable iff (!rst_n)
    sum_vld_q |=> !sum_vld_q);

  // R10: the last internal step leaves X empty
  a_r10_x_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op == OP_ST4) |-> (x_q == '0));

endmodule

// File: rtl/bitser_pe_array.sv
module bitser_pe_array
  import bsp_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [3:0]        in_tt,
  input  logic [LANES-1:0]  in_slice,
  output logic [LANES-1:0]  x_out,
  output logic [LANES-1:0]  y_out,
  output logic [LANES-1:0]  sum_out,
  output logic              sum_vld,
  output logic              busy
);

  logic    rst_s1, rst_s2;
  bsp_op_e op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  bsp_seq_ctrl u_ctrl (
    .clk  (clk),
    .rst_n(rst_s2),
    .vld  (in_vld),
    .mode (in_mode),
    .op   (op),
    .busy (busy)
  );

  bsp_xy_datapath #(.W(LANES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_s2),
    .op       (op),
    .tt       (in_tt),
    .f        (in_slice),
    .x_q      (x_out),
    .y_q      (y_out),
    .sum_q    (sum_out),
    .sum_vld_q(sum_vld)
  );

  // R9: a sum pulse only appears while the sequencer is busy
  a_r9_pulse_in_busy: assert property (@(posedge clk) disable iff (!rst_s2)
    sum_vld |-> busy);

endmodule

// File: tb/bitser_pe_array_test.sv
`timescale 1ns/1ps
module bitser_pe_array_test;
  localparam int W  = 16;
  localparam int FW = 6;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_vld;
  logic [2:0]   in_mode;
  logic [3:0]   in_tt;
  logic [W-1:0] in_slice;
  logic [W-1:0] x_out, y_out, sum_out;
  logic         sum_vld, busy;

  always #2 clk = ~clk;

  bitser_pe_array #(.LANES(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mode(in_mode),
    .in_tt(in_tt), .in_slice(in_slice), .x_out(x_out), .y_out(y_out),
    .sum_out(sum_out), .sum_vld(sum_vld), .busy(busy)
  );

  typedef struct {
    logic [W-1:0] ex;
    logic [W-1:0] ey;
    logic [W-1:0] es;
    logic         esv;
    logic         ebusy;
    string        req;
  } exp_t;

  exp_t         sb[$];
  int           total = 0;
  int           bad   = 0;
  logic [W-1:0] mx = '0, my = '0, msum = '0;
  int           mph = 0;

  function automatic logic [W-1:0] fn(input logic [3:0] t, input logic [W-1:0] s,
                                      input logic [W-1:0] f);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = t[{s[i], f[i]}];
    return r;
  endfunction

  task automatic step(input logic v, input logic [2:0] md, input logic [3:0] t,
                      input logic [W-1:0] s, input string req);
    exp_t         e;
    logic [W-1:0] fx, fy;
    logic         sv;
    @(negedge clk);
    in_vld = v; in_mode = md; in_tt = t; in_slice = s;
    fx = fn(t, mx, s);
    fy = fn(t, my, s);
    sv = 1'b0;
    case (mph)
      2: begin msum = my; sv = 1'b1; mx = mx ^ my; mph = 3; end
      3: begin my = my ^ mx; mx = '0; mph = 0; end
      1: if (v && md == 3'd6) begin mx = mx ^ (my & s); my = my ^ s; mph = 2; end
      default: if (v) begin
        case (md)
          3'd0: mx = fx;
          3'd1: my = fy;
          3'd2: begin mx = fx; my = fy; end
          3'd3: mx = (fx & my) | (mx & ~my);
          3'd4: begin mx = (fx & my) | (mx & ~my); my = fy; end
          3'd5: begin mx = mx ^ (my & s); my = my ^ s; mph = 1; end
          default: ;
        endcase
      end
    endcase
    e.ex = mx; e.ey = my; e.es = msum; e.esv = sv;
    e.ebusy = (mph == 2) || (mph == 3); e.req = req;
    sb.push_back(e);
  endtask

  // monitor: one expected item per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (x_out !== e.ex || y_out !== e.ey || sum_vld !== e.esv || busy !== e.ebusy ||
            (e.esv && sum_out !== e.es)) begin
          bad++;
          $display("FAIL %s: x=%h y=%h sv=%b sum=%h busy=%b expected x=%h y=%h sv=%b sum=%h busy=%b",
                   e.req, x_out, y_out, sum_vld, sum_out, busy,
                   e.ex, e.ey, e.esv, e.es, e.ebusy);
        end
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [FW-1:0] a [W];
    logic [FW-1:0] b [W];
    logic [FW:0]   got [W];
    logic [W-1:0]  sa, sbv;
    int            arith_bad;

    rst_n = 1'b0; in_vld = 1'b0; in_mode = '0; in_tt = '0; in_slice = '0;
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (x_out !== '0 || y_out !== '0 || sum_vld !== 1'b0 || busy !== 1'b0 || sum_out !== '0) begin
      bad++;
      $display("FAIL R1: x=%h y=%h sv=%b busy=%b expected all zero", x_out, y_out, sum_vld, busy);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 after release
    step(1'b0, 3'd0, 4'h0, '0, "R1");
    // R2..R6 with random tables and slices
    for (int k = 0; k < 6; k++) step(1'b1, 3'd0, 4'($urandom), W'($urandom), "R2");
    step(1'b1, 3'd0, 4'b1010, W'($urandom), "R2");
    for (int k = 0; k < 6; k++) step(1'b1, 3'd1, 4'($urandom), W'($urandom), "R3");
    for (int k = 0; k < 6; k++) step(1'b1, 3'd2, 4'($urandom), W'($urandom), "R4");
    for (int k = 0; k < 8; k++) step(1'b1, 3'd3, 4'($urandom), W'($urandom), "R5");
    for (int k = 0; k < 8; k++) step(1'b1, 3'd4, 4'($urandom), W'($urandom), "R6");
    step(1'b1, 3'd4, 4'b0101, W'($urandom), "R6");
    // R7: idle strobe and reserved code
    step(1'b0, 3'd2, 4'hF, '1, "R7");
    step(1'b1, 3'd7, 4'hF, '1, "R7");
    // R11: code 6 with no add pending
    step(1'b1, 3'd6, 4'h0, '1, "R11");
    // R8/R11: A slice, stray codes, then B slice
    step(1'b1, 3'd5, 4'h0, W'($urandom), "R8");
    step(1'b1, 3'd0, 4'hF, '1, "R11");
    step(1'b1, 3'd5, 4'h0, '1, "R11");
    step(1'b1, 3'd6, 4'h0, W'($urandom), "R8");
    step(1'b1, 3'd2, 4'hF, '1, "R11");
    step(1'b1, 3'd1, 4'h0, '1, "R9");
    step(1'b0, 3'd0, 4'h0, '0, "R10");

    // R9/R10: full multi-bit add
    for (int l = 0; l < W; l++) begin a[l] = FW'($urandom); b[l] = FW'($urandom); end
    step(1'b1, 3'd2, 4'h0, '0, "R4");
    for (int k = 0; k < FW; k++) begin
      for (int l = 0; l < W; l++) begin sa[l] = a[l][k]; sbv[l] = b[l][k]; end
      step(1'b1, 3'd5, 4'h0, sa, "R8");
      step(1'b1, 3'd6, 4'h0, sbv, "R8");
      step(1'b1, 3'd0, 4'($urandom), W'($urandom), "R11");
      @(posedge clk);
      #1;
      for (int l = 0; l < W; l++) got[l][k] = sum_out[l];
      step(1'b1, 3'd3, 4'($urandom), W'($urandom), "R10");
    end
    @(posedge clk);
    #1;
    for (int l = 0; l < W; l++) got[l][FW] = y_out[l];
    arith_bad = 0;
    for (int l = 0; l < W; l++) begin
      if (got[l] !== ({1'b0, a[l]} + {1'b0, b[l]})) begin
        arith_bad++;
        $display("FAIL R10: lane %0d sum=%0d expected=%0d", l, got[l], a[l] + b[l]);
      end
    end
    total++;
    if (arith_bad != 0) bad++;

    step(1'b0, 3'd0, 4'h0, '0, "R7");
    repeat (3) @(posedge clk);
    #2;
    summary();
  end

endmodule